// File: doc/BRIEF.md
# Fault Collection and Injection Unit

This block gathers five software-recoverable and sixteen hardware-recoverable fault lines into one sticky flag register. Each fault source can be enabled or disabled, and a second per-source bit picks whether an enabled fault drives the unit into an Alarm state or a Fault state. Software clears latched flags by writing ones to them, and the unit falls back to Normal once no enabled flag is left.

To check this reaction path on a live chip, software can raise a test-mode input and write an injection register. Each injected bit latches its flag exactly as a real fault on that source would. While test mode is on, the real fault lines are not sampled. Software faults 0 and 1 cannot be injected.

The enable and target registers are writable only while the unit sits in its Init state and the configuration lock is clear. The lock is a one-way bit. Software can set it directly, and leaving Init sets it as well.

Top module: `fcu_top`

## Requirements
- R1: After reset every register reads zero, `state_o` is 0 (Init) and `fault_o` is 0.
- R2: In the flag and injection registers, software fault k (k = 0..4) is at bit 31-k and hardware fault j (j = 0..15) is at bit j. Bits 16 to 26 always read zero. Register addresses are 0 flags, 1 injection, 2 enable, 3 target, 4 control.
- R3: With test mode off, a one-cycle pulse on a raw fault line sets its flag at the next clock edge. The flag stays set after the line drops.
- R4: A write to the flag register clears every flag whose write-data bit is 1 and leaves every flag whose write-data bit is 0 unchanged.
- R5: While `test_mode_i` is 1, raw fault lines set no flag.
- R6: A write to the injection register while `test_mode_i` is 1 holds the written bits for one cycle and sets the matching flags one edge later. A write while `test_mode_i` is 0 has no effect.
- R7: Injection bits for software faults 0 and 1 (bits 31 and 30) never set a flag.
- R8: State codes are 0 Init, 1 Normal, 2 Alarm, 3 Fault. Writing control bit 1 moves Init to Normal, and the unit never returns to Init. Outside Init, one edge after the flags change, the state becomes Alarm if some latched flag has its enable bit set and its target bit at 0. It becomes Fault if such a flag has its target bit at 1. Latched flags whose enable bit is 0 cause no change.
- R9: When enabled flags of both targets are latched, the state is Fault. `fault_o` is 1 exactly when `state_o` is 3.
- R10: The enable and target registers accept writes only while the lock is clear. Control bit 0 sets the lock, and so does the control bit 1 write that leaves Init. Only reset clears the lock. Reading the control register returns the lock in bit 0, test mode in bit 1 and the state in bits 5:4.
- R11: Once all enabled flags are cleared, the state returns to Normal at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write enable |
| rdata | output | 32 | Read data for `addr` (combinational) |
| sw_fault_i | input | 5 | Raw software-recoverable fault lines |
| hw_fault_i | input | 16 | Raw hardware-recoverable fault lines |
| test_mode_i | input | 1 | Test mode: blocks raw faults, allows injection |
| state_o | output | 2 | Current state code |
| fault_o | output | 1 | High while in Fault state |

## Verification
The bench sweeps every one of the 32 injection bit positions and every raw source. A reversed software-fault bit order or a lost injection mask therefore shows up as a flag at the wrong position, or as a flag for software faults 0 and 1. Several enable and target configurations are driven with single faults and with mixed patterns. A design that gave Alarm priority over Fault, or that reacted to disabled flags, would report the wrong state. The bench also writes the enable register after the lock is set and sends real faults during test mode. A design that did not honour the lock would read back changed enables, and one that did not gate the raw lines would latch those faults.

// File: rtl/fcu_pkg.sv
// Package: shared widths, register addresses, state codes and bit-layout
// helpers for the fault collection unit.
package fcu_pkg;
    localparam int REG_W     = 32;
    localparam int NUM_SW    = 5;
    localparam int NUM_HW    = 16;
    localparam int NUM_NOINJ = 2;   // software faults 0..NUM_NOINJ-1 not injectable
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_FLAG = 3'd0;
    localparam logic [ADDR_W-1:0] A_INJ  = 3'd1;
    localparam logic [ADDR_W-1:0] A_ENA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TGT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;

    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_NORMAL = 2'd1,
        ST_ALARM  = 2'd2,
        ST_FAULT  = 2'd3
    } fcu_state_t;

    // Bit position of software fault k (first-numbered bit is the MSB).
    function automatic int sw_pos(input int k);
        return REG_W - 1 - k;
    endfunction

    // Mask of all implemented flag bits.
    function automatic logic [REG_W-1:0] valid_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int j = 0; j < NUM_HW; j++) m[j] = 1'b1;
        for (int k = 0; k < NUM_SW; k++) m[sw_pos(k)] = 1'b1;
        return m;
    endfunction

    // Mask of bits that an injection may set.
    function automatic logic [REG_W-1:0] inj_mask();
        logic [REG_W-1:0] m;
        m = valid_mask();
        for (int k = 0; k < NUM_NOINJ; k++) m[sw_pos(k)] = 1'b0;
        return m;
    endfunction

    // Place raw fault vectors into the register layout.
    function automatic logic [REG_W-1:0] pack_faults(
        input logic [NUM_SW-1:0] sw,
        input logic [NUM_HW-1:0] hw
    );
        logic [REG_W-1:0] v;
        v = '0;
        for (int j = 0; j < NUM_HW; j++) v[j] = hw[j];
        for (int k = 0; k < NUM_SW; k++) v[sw_pos(k)] = sw[k];
        return v;
    endfunction
endpackage

// File: rtl/fcu_regs.sv
// Module: fcu_regs
// Holds the configuration (enable, target, lock) and the one-cycle injection
// register. Assumes the bus is single-cycle: a write is taken when we is high
// at a clock edge. Enable and target are frozen once the lock is set.
module fcu_regs
    import fcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              test_mode_i,
    output logic [REG_W-1:0]  ena_q,
    output logic [REG_W-1:0]  tgt_q,
    output logic              lock_q,
    output logic [REG_W-1:0]  inj_q,
    output logic              go_req
);
    localparam logic [REG_W-1:0] VALID = valid_mask();
    localparam logic [REG_W-1:0] INJOK = inj_mask();

    logic wr_ena, wr_tgt, wr_inj, wr_ctrl;

    // Decode write strobes for each register.
    always_comb begin
        wr_ena  = we && (addr == A_ENA) && !lock_q;
        wr_tgt  = we && (addr == A_TGT) && !lock_q;
        wr_inj  = we && (addr == A_INJ) && test_mode_i;
        wr_ctrl = we && (addr == A_CTRL);
        go_req  = wr_ctrl && wdata[1];
    end

    // Enable and target registers, writable only before the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= '0;
            tgt_q <= '0;
        end else begin
            if (wr_ena) ena_q <= wdata & VALID;
            if (wr_tgt) tgt_q <= wdata & VALID;
        end
    end

    // One-way configuration lock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (wr_ctrl && (wdata[0] || wdata[1]))
            lock_q <= 1'b1;
    end

    // Injection pulse register: holds a test-mode write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inj_q <= '0;
        else if (wr_inj)
            inj_q <= wdata & INJOK;
        else
            inj_q <= '0;
    end
endmodule

// File: rtl/fcu_flags.sv
// Module: fcu_flags
// Sticky fault flags. Raw lines are sampled only outside test mode; injected
// bits set flags the same way. Write-one-to-clear, with set winning over clear.
module fcu_flags
    import fcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SW-1:0] sw_fault_i,
    input  logic [NUM_HW-1:0] hw_fault_i,
    input  logic              test_mode_i,
    input  logic [REG_W-1:0]  inj,
    input  logic              clr_we,
    input  logic [REG_W-1:0]  clr_bits,
    output logic [REG_W-1:0]  flags_q
);
    localparam logic [REG_W-1:0] VALID = valid_mask();

    logic [REG_W-1:0] real_set, set_v, clr_v;

    // Gather set and clear vectors for this cycle.
    always_comb begin
        real_set = test_mode_i ? '0 : pack_faults(sw_fault_i, hw_fault_i);
        set_v    = (real_set | inj) & VALID;
        clr_v    = clr_we ? clr_bits : '0;
    end

    // Latch flags.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= ((flags_q & ~clr_v) | set_v) & VALID;
    end
endmodule

// File: rtl/fcu_state.sv
// Module: fcu_state
// Reaction state machine. Leaves Init only on a run request; afterwards it
// follows the enabled latched flags, Fault taking priority over Alarm.
module fcu_state
    import fcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] flags,
    input  logic [REG_W-1:0] ena,
    input  logic [REG_W-1:0] tgt,
    input  logic             go_req,
    output fcu_state_t       state_q
);
    logic       any_alarm, any_fault;
    fcu_state_t state_n;

    // Reduce enabled flags per target.
    always_comb begin
        any_fault = |(flags & ena & tgt);
        any_alarm = |(flags & ena & ~tgt);
    end

    // Next-state selection.
    always_comb begin
        if (state_q == ST_INIT)
            state_n = go_req ? ST_NORMAL : ST_INIT;
        else if (any_fault)
            state_n = ST_FAULT;
        else if (any_alarm)
            state_n = ST_ALARM;
        else
            state_n = ST_NORMAL;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_n;
    end
endmodule

// File: rtl/fcu_top.sv
// Module: fcu_top
// Fault collection unit top: register bus decode, read mux, and wiring of the
// configuration, flag and state submodules. Reads are combinational.
module fcu_top
    import fcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              we,
    output logic [REG_W-1:0]  rdata,
    input  logic [NUM_SW-1:0] sw_fault_i,
    input  logic [NUM_HW-1:0] hw_fault_i,
    input  logic              test_mode_i,
    output logic [1:0]        state_o,
    output logic              fault_o
);
    logic [REG_W-1:0] ena_q, tgt_q, inj_q, flags_q;
    logic             lock_q, go_req, clr_we;
    fcu_state_t       state_q;

    fcu_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .test_mode_i(test_mode_i), .ena_q(ena_q), .tgt_q(tgt_q),
        .lock_q(lock_q), .inj_q(inj_q), .go_req(go_req)
    );

    // Flag clear strobe.
    assign clr_we = we && (addr == A_FLAG);

    fcu_flags u_flags (
        .clk(clk), .rst_n(rst_n), .sw_fault_i(sw_fault_i),
        .hw_fault_i(hw_fault_i), .test_mode_i(test_mode_i), .inj(inj_q),
        .clr_we(clr_we), .clr_bits(wdata), .flags_q(flags_q)
    );

    fcu_state u_state (
        .clk(clk), .rst_n(rst_n), .flags(flags_q), .ena(ena_q), .tgt(tgt_q),
        .go_req(go_req), .state_q(state_q)
    );

    // Status outputs.
    assign state_o = state_q;
    assign fault_o = (state_q == ST_FAULT);

    // Read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_FLAG:  rdata = flags_q;
            A_INJ:   rdata = inj_q;
            A_ENA:   rdata = ena_q;
            A_TGT:   rdata = tgt_q;
            A_CTRL:  begin
                rdata[0]   = lock_q;
                rdata[1]   = test_mode_i;
                rdata[5:4] = state_q;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/fcu_checker.sv
// Module: fcu_checker
// Temporal checks on the fault collection unit, bound to fcu_top.
module fcu_checker
    import fcu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             test_mode_i,
    input logic [REG_W-1:0] flags,
    input logic [REG_W-1:0] inj,
    input logic [REG_W-1:0] ena,
    input logic             lock,
    input logic [1:0]       state
);
    localparam logic [REG_W-1:0] VALID = valid_mask();
    localparam logic [REG_W-1:0] INJOK = inj_mask();

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~VALID) == '0);  // R2
    AST_INJ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (inj & ~INJOK) == '0);  // R7
    AST_NO_REAL_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(test_mode_i) && ($past(inj) == '0)) |-> ((flags & ~$past(flags)) == '0));  // R5
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);  // R10
    AST_ENA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(ena));  // R10
    AST_INIT_ONEWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd0) |=> (state != 2'd0));  // R8
endmodule

bind fcu_top fcu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode_i), .flags(flags_q),
    .inj(inj_q), .ena(ena_q), .lock(lock_q), .state(state_o)
);

// File: tb/tb_fcu_top.sv
module tb_fcu_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VALID = 32'hF800_FFFF;
    localparam logic [31:0] INJOK = 32'h3800_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic [4:0]  sw_fault_i = '0;
    logic [15:0] hw_fault_i = '0;
    logic        test_mode_i = 1'b0;
    logic [1:0]  state_o;
    logic        fault_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    fcu_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .rdata(rdata), .sw_fault_i(sw_fault_i), .hw_fault_i(hw_fault_i),
        .test_mode_i(test_mode_i), .state_o(state_o), .fault_o(fault_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0; test_mode_i = 1'b0;
        sw_fault_i = '0; hw_fault_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive raw lines from a register-layout pattern for one cycle.
    task automatic pulse_raw(input logic [31:0] p);
        @(negedge clk);
        for (int k = 0; k < 5; k++) sw_fault_i[k] = p[31-k];
        hw_fault_i = p[15:0];
        @(negedge clk);
        sw_fault_i = '0; hw_fault_i = '0;
    endtask

    function automatic logic [31:0] src_bit(input int i);
        return (i < 5) ? (32'h1 << (31 - i)) : (32'h1 << (i - 5));
    endfunction

    function automatic logic [1:0] exp_state(input logic [31:0] f, input logic [31:0] e,
                                             input logic [31:0] t);
        if ((f & e & t) != 0) return 2'd3;
        if ((f & e & ~t) != 0) return 2'd2;
        return 2'd1;
    endfunction

    function automatic logic [31:0] lfsr(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, ena, tgt, seed, pat;
        do_reset();

        // R1: reset values
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], d);
            check("R1 reg reset", d, 32'h0);
        end
        check("R1 state", {30'h0, state_o}, 32'h0);
        check("R1 fault_o", {31'h0, fault_o}, 32'h0);

        // R2/R3: every raw source latches at its own bit and stays set
        for (int i = 0; i < 21; i++) begin
            pulse_raw(src_bit(i));
            rd(3'd0, d);
            check("R2 R3 raw latch position", d, src_bit(i));
            wr(3'd0, 32'h0);
            rd(3'd0, d);
            check("R4 zero write keeps flag", d, src_bit(i));
            wr(3'd0, src_bit(i));
            rd(3'd0, d);
            check("R4 w1c clears", d, 32'h0);
        end
        // R2: all lines at once; unused bits stay zero
        pulse_raw(32'hFFFF_FFFF);
        rd(3'd0, d);
        check("R2 reserved bits zero", d, VALID);
        wr(3'd0, 32'h0000_00F0);
        rd(3'd0, d);
        check("R4 partial clear", d, VALID & ~32'h0000_00F0);
        wr(3'd0, 32'hFFFF_FFFF);
        check("R1 state stays Init", {30'h0, state_o}, 32'h0);

        // R6: injection outside test mode ignored
        wr(3'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(3'd0, d);
        check("R6 inject outside test ignored", d, 32'h0);

        // R5: raw faults blocked in test mode
        test_mode_i = 1'b1;
        pulse_raw(32'hFFFF_FFFF);
        rd(3'd0, d);
        check("R5 raw blocked in test mode", d, 32'h0);
        rd(3'd4, d);
        check("R10 ctrl shows test bit", d, 32'h2);

        // R6/R7: sweep every injection bit
        for (int b = 0; b < 32; b++) begin
            wr(3'd1, 32'h1 << b);
            @(negedge clk);
            rd(3'd0, d);
            check("R6 R7 inject sweep", d, (32'h1 << b) & INJOK);
            wr(3'd0, 32'hFFFF_FFFF);
        end
        test_mode_i = 1'b0;

        // R8-R11: several enable/target configurations
        seed = 32'h1D2C_3B4A;
        for (int c = 0; c < 6; c++) begin
            do_reset();
            seed = lfsr(lfsr(seed));
            ena = (c == 0) ? 32'h0 : ((c == 1) ? VALID : (seed & VALID));
            seed = lfsr(lfsr(seed));
            tgt = (c == 1) ? 32'h0 : (seed & VALID);
            wr(3'd2, ena);
            wr(3'd3, tgt);
            rd(3'd2, d);
            check("R10 enable writable before lock", d, ena);
            rd(3'd3, d);
            check("R10 target writable before lock", d, tgt);
            wr(3'd4, 32'h2);
            check("R8 leave Init", {30'h0, state_o}, 32'h1);
            rd(3'd4, d);
            check("R10 lock set on leaving Init", d, 32'h11);
            wr(3'd2, ~ena);
            wr(3'd3, ~tgt);
            rd(3'd2, d);
            check("R10 enable frozen", d, ena);
            rd(3'd3, d);
            check("R10 target frozen", d, tgt);

            for (int i = 0; i < 21; i++) begin
                pulse_raw(src_bit(i));
                @(negedge clk);
                check("R8 single source state", {30'h0, state_o},
                      {30'h0, exp_state(src_bit(i), ena, tgt)});
                check("R9 fault_o", {31'h0, fault_o},
                      {31'h0, exp_state(src_bit(i), ena, tgt) == 2'd3});
                wr(3'd0, 32'hFFFF_FFFF);
                @(negedge clk);
                check("R11 back to Normal", {30'h0, state_o}, 32'h1);
            end
            for (int r = 0; r < 8; r++) begin
                seed = lfsr(lfsr(lfsr(seed)));
                pat = seed & VALID;
                pulse_raw(pat);
                @(negedge clk);
                check("R9 mixed pattern state", {30'h0, state_o},
                      {30'h0, exp_state(pat, ena, tgt)});
                wr(3'd0, 32'hFFFF_FFFF);
                @(negedge clk);
            end
        end

        // R9/R11: Fault over Alarm, then drop back to Alarm
        do_reset();
        wr(3'd2, VALID);
        wr(3'd3, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd4, d);
        check("R10 direct lock bit, still Init", d, 32'h1);
        wr(3'd4, 32'h2);
        pulse_raw(32'h3);
        @(negedge clk);
        check("R9 Fault priority", {30'h0, state_o}, 32'h3);
        wr(3'd0, 32'h1);
        @(negedge clk);
        check("R11 Fault cleared leaves Alarm", {30'h0, state_o}, 32'h2);
        wr(3'd0, 32'h2);
        @(negedge clk);
        check("R11 Normal", {30'h0, state_o}, 32'h1);

        // R8: injected fault reacts like a real one
        test_mode_i = 1'b1;
        wr(3'd1, 32'h1);
        @(negedge clk);
        @(negedge clk);
        check("R6 R8 injected fault reaction", {30'h0, state_o}, 32'h3);
        test_mode_i = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule